// File: doc/BRIEF.md
# Stopwatch and Reloading Interval Timer

This peripheral pairs two tick-driven counters behind a small register port. A prescaler divides the system clock into timer ticks. A 12-bit stopwatch counts those ticks and wraps freely. An interval timer counts the same ticks, reloads itself from a programmable 16-bit reload register, and latches a pending interrupt each time its period runs out.

The pending flag stays set until the processor acknowledges the interrupt. The interrupt line is the pending flag qualified by an enable input. Software clears the stopwatch by writing any value to it. It programs the timer by writing the reload register as a full word or as a single byte, and it reads either register back through one read mux. The block has no data stream, so every pin is a plain control or status signal.

Top module: `swt_timer`

## Requirements
- R1: The stopwatch advances by exactly one on every tick and wraps from 0xFFF to 0x000. It holds its value between ticks.
- R2: Any write to the stopwatch register (select 0), whatever the data, sets the stopwatch to zero on the next clock. A write wins over a tick in the same cycle.
- R3: `tick_o` is high for one clock in every TICK_DIV clocks. The first tick after reset falls on clock TICK_DIV-1.
- R4: While the timer is stopped, a tick loads the running count from the reload register. That tick does not count toward a period.
- R5: Once loaded with a nonzero value N, the timer sets the pending flag on the (N+1)-th following tick, reloads in the same step, and repeats every N+1 ticks while the reload stays N.
- R6: A reload value of zero stops the timer and never sets pending. A nonzero value written later is loaded on the next tick.
- R7: Only `irq_ack_i` clears the pending flag. If an expiry and an acknowledge fall in the same cycle, the flag stays set.
- R8: `irq_o` equals the pending flag AND `irq_en_i`.
- R9: A write to select 1 stores the reload value. With `wr_byte_i` high, the low data byte is copied into both bytes. `rd_data_o` returns the stopwatch, zero-extended, for `rd_sel_i`=0 and the reload register for `rd_sel_i`=1. Neither register changes when it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 stopwatch, 1 reload |
| wr_byte_i | input | 1 | Byte-wide write; low byte is copied to both bytes |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 1 | Read source: 0 stopwatch, 1 reload |
| rd_data_o | output | DATA_W | Read data, combinational from the select |
| irq_en_i | input | 1 | Interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| tick_o | output | 1 | Prescaler tick strobe |
| stopwatch_o | output | SW_W | Current stopwatch value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with TICK_DIV=4 and keeps the 12-bit stopwatch and the 16-bit data width. A short tick period means the full 4096-tick stopwatch wrap and several timer periods, including a 258-tick period set by a byte write, all finish within a few tens of thousands of clocks. The small divider also makes it easy to place a stopwatch write on the same clock as a tick, and to run back-to-back expiries against acknowledges.

// File: rtl/swt_pkg.sv
package swt_pkg;
  typedef enum logic {
    SEL_STOPWATCH = 1'b0,
    SEL_RELOAD    = 1'b1
  } swt_sel_e;
endpackage

// File: rtl/swt_prescaler.sv
module swt_prescaler #(
  parameter int unsigned TICK_DIV = 384
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;

  assign tick_o = (div_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/swt_stopwatch.sv
module swt_stopwatch #(
  parameter int unsigned SW_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            clear_i,
  output logic [SW_W-1:0] count_o
);
  logic [SW_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (clear_i) count_q <= '0;
    else if (tick_i)  count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
endmodule

// File: rtl/swt_interval.sv
module swt_interval #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] remain_q;
  logic             run_q;

  // An expiry is the tick that finds a running count already at zero.
  assign expire_o = tick_i && run_q && (remain_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      run_q    <= 1'b0;
    end else if (tick_i) begin
      if (!run_q || remain_q == '0) begin
        remain_q <= reload_i;
        run_q    <= (reload_i != '0);
      end else begin
        remain_q <= remain_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/swt_timer.sv
module swt_timer #(
  parameter int unsigned TICK_DIV = 384,
  parameter int unsigned SW_W     = 12,
  parameter int unsigned DATA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic              wr_byte_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              irq_en_i,
  input  logic              irq_ack_i,
  output logic              tick_o,
  output logic [SW_W-1:0]   stopwatch_o,
  output logic              irq_o
);
  import swt_pkg::*;

  localparam int unsigned HALF_W = DATA_W / 2;

  logic              tick;
  logic              sw_clear;
  logic              reload_wr;
  logic [DATA_W-1:0] wr_word;
  logic [DATA_W-1:0] reload_q;
  logic              expire;
  logic              pend_q;

  swt_prescaler #(.TICK_DIV(TICK_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  assign sw_clear  = wr_en_i && (swt_sel_e'(wr_sel_i) == SEL_STOPWATCH);
  assign reload_wr = wr_en_i && (swt_sel_e'(wr_sel_i) == SEL_RELOAD);

  swt_stopwatch #(.SW_W(SW_W)) u_sw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .clear_i(sw_clear),
    .count_o(stopwatch_o)
  );

  // Byte writes are widened: the low byte lands in both halves.
  assign wr_word = wr_byte_i ? {2{wr_data_i[HALF_W-1:0]}} : wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        reload_q <= '0;
    else if (reload_wr) reload_q <= wr_word;
  end

  swt_interval #(.CNT_W(DATA_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .reload_i(reload_q),
    .expire_o(expire)
  );

  // A new expiry outranks an acknowledge in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (expire)    pend_q <= 1'b1;
    else if (irq_ack_i) pend_q <= 1'b0;
  end

  assign irq_o     = pend_q && irq_en_i;
  assign tick_o    = tick;
  assign rd_data_o = (swt_sel_e'(rd_sel_i) == SEL_RELOAD) ? reload_q
                                                          : DATA_W'(stopwatch_o);
endmodule

// File: rtl/swt_timer_chk.sv
module swt_timer_chk #(
  parameter int unsigned TICK_DIV = 384,
  parameter int unsigned SW_W     = 12,
  parameter int unsigned DATA_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic              wr_byte_i,
  input logic              irq_en_i,
  input logic              irq_ack_i,
  input logic              tick_o,
  input logic [SW_W-1:0]   stopwatch_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] reload_q
);
  localparam int unsigned HALF_W = DATA_W / 2;

  p_sw_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> (stopwatch_o == '0));

  p_sw_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !(wr_en_i && !wr_sel_i)) |=> (stopwatch_o == SW_W'($past(stopwatch_o) + 1'b1)));

  p_sw_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !(wr_en_i && !wr_sel_i)) |=> $stable(stopwatch_o));

  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

  p_pend_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i && irq_en_i) |=> (irq_o || !irq_en_i));

  p_byte_widen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && wr_byte_i) |=> (reload_q[DATA_W-1:HALF_W] == reload_q[HALF_W-1:0]));

  generate
    if (TICK_DIV > 1) begin : g_tick_gap
      p_tick_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

bind swt_timer swt_timer_chk #(
  .TICK_DIV(TICK_DIV),
  .SW_W    (SW_W),
  .DATA_W  (DATA_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_byte_i  (wr_byte_i),
  .irq_en_i   (irq_en_i),
  .irq_ack_i  (irq_ack_i),
  .tick_o     (tick_o),
  .stopwatch_o(stopwatch_o),
  .irq_o      (irq_o),
  .reload_q   (reload_q)
);

// File: tb/swt_timer_tb.sv
module swt_timer_tb_top;
  localparam int unsigned TDIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, wr_byte = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [15:0] rd_data;
  logic        irq_en = 1'b0, irq_ack = 1'b0;
  logic        tick;
  logic [11:0] sw;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  swt_timer #(.TICK_DIV(TDIV), .SW_W(12), .DATA_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_byte_i(wr_byte), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .irq_en_i(irq_en), .irq_ack_i(irq_ack),
    .tick_o(tick), .stopwatch_o(sw), .irq_o(irq));

  // Reference model written from the requirements.
  int unsigned m_div = 0;
  logic [11:0] m_sw = '0;
  logic [15:0] m_rl = '0, m_cnt = '0;
  logic        m_run = 1'b0, m_pend = 1'b0;

  always @(posedge clk) begin
    logic mt, fire;
    if (!rst_n) begin
      m_div = 0; m_sw = '0; m_rl = '0; m_cnt = '0; m_run = 1'b0; m_pend = 1'b0;
    end else begin
      mt = (m_div == TDIV - 1);
      fire = 1'b0;
      m_div = mt ? 0 : m_div + 1;
      if (wr_en && !wr_sel) m_sw = '0;
      else if (mt) m_sw = m_sw + 12'd1;
      if (mt) begin
        if (!m_run) begin m_cnt = m_rl; m_run = (m_rl != 0); end
        else if (m_cnt == 0) begin m_cnt = m_rl; m_run = (m_rl != 0); fire = 1'b1; end
        else m_cnt = m_cnt - 16'd1;
      end
      if (fire) m_pend = 1'b1;
      else if (irq_ack) m_pend = 1'b0;
      if (wr_en && wr_sel) m_rl = wr_byte ? {2{wr_data[7:0]}} : wr_data;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Continuous comparison of the observable outputs against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      check(tick == (m_div == TDIV - 1), "R3 tick strobe", int'(tick), int'(m_div == TDIV - 1));
      check(sw == m_sw, "R1 R2 stopwatch", int'(sw), int'(m_sw));
      check(irq == (m_pend && irq_en), "R5 R7 R8 irq", int'(irq), int'(m_pend && irq_en));
    end
  end

  // Scoreboard for register reads.
  typedef struct { logic sel; logic [15:0] v; string tag; } rd_item_t;
  rd_item_t sb_q[$];

  initial begin
    forever begin
      rd_item_t it;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      check(rd_data == it.v, it.tag, int'(rd_data), int'(it.v));
    end
  end

  task automatic expect_rd(input logic sel, input logic [15:0] v, input string tag);
    rd_item_t it;
    @(negedge clk);
    rd_sel = sel;
    #0.5;
    it.sel = sel; it.v = v; it.tag = tag;
    sb_q.push_back(it);
    #0.5;
  endtask

  task automatic do_wr(input logic sel, input logic byt, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_byte = byt; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  // Counts ticks, sampled at negedges, until irq is seen high.
  task automatic ticks_to_irq(output int n);
    n = 0;
    forever begin
      if (irq) break;
      if (tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic main_seq();
    int n;
    int gap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state
    expect_rd(1'b0, 16'h0000, "R9 reset stopwatch read");
    expect_rd(1'b1, 16'h0000, "R9 reset reload read");
    check(irq == 1'b0, "R8 irq after reset", int'(irq), 0);

    // R3: tick spacing
    @(negedge clk); while (!tick) @(negedge clk);
    gap = 0;
    @(negedge clk); gap++;
    while (!tick) begin @(negedge clk); gap++; end
    check(gap == TDIV, "R3 tick period", gap, TDIV);

    // R6: zero reload never fires
    irq_en = 1'b1;
    repeat (60) @(negedge clk);
    check(irq == 1'b0, "R6 zero reload idle", int'(irq), 0);

    // R4 R5: reload 2 -> load tick + 3 ticks
    do_wr(1'b1, 1'b0, 16'h0002);
    expect_rd(1'b1, 16'h0002, "R9 full word reload");
    ticks_to_irq(n);
    check(n == 4, "R4 load tick then first expiry", n, 4);
    // R7: no ack -> pending holds
    repeat (20) @(negedge clk);
    check(irq == 1'b1, "R7 pending held without ack", int'(irq), 1);
    // R8: gate off
    irq_en = 1'b0;
    @(negedge clk); #0.5;
    check(irq == 1'b0, "R8 irq masked", int'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk); #0.5;
    check(irq == 1'b1, "R8 irq unmasked", int'(irq), 1);
    // Ack just after an expiry, then measure the next period
    @(negedge clk); while (!tick) @(negedge clk);
    @(negedge clk);
    do_ack();
    ticks_to_irq(n);
    check(n == 3, "R5 steady period N+1", n, 3);

    // R9: byte write widened
    do_wr(1'b1, 1'b1, 16'h1234);
    expect_rd(1'b1, 16'h3434, "R9 byte write widened");
    do_wr(1'b1, 1'b1, 16'h0001);
    expect_rd(1'b1, 16'h0101, "R9 byte write 0x01");
    do_ack();
    repeat (2000) @(negedge clk);
    // R6: stop with zero, then restart with nonzero
    do_wr(1'b1, 1'b0, 16'h0000);
    repeat (300 * TDIV) @(negedge clk);
    do_ack();
    repeat (40) @(negedge clk);
    check(irq == 1'b0, "R6 stopped by zero reload", int'(irq), 0);
    do_wr(1'b1, 1'b0, 16'h0001);
    ticks_to_irq(n);
    check(n == 3, "R6 restart loads on next tick", n, 3);
    do_ack();

    // R2: any value clears
    repeat (50) @(negedge clk);
    do_wr(1'b0, 1'b0, 16'hABCD);
    expect_rd(1'b0, 16'h0000, "R2 write clears stopwatch");
    // R2: write coinciding with a tick
    @(negedge clk); while (!tick) @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0FFF;
    @(negedge clk); wr_en = 1'b0;
    #0.5;
    check(sw == 12'h000, "R2 write beats tick", int'(sw), 0);

    // R1: wrap from 0xFFF to 0
    while (sw != 12'hFFF) @(negedge clk);
    while (!tick) @(negedge clk);
    @(negedge clk);
    check(sw == 12'h000, "R1 stopwatch wrap", int'(sw), 0);
    expect_rd(1'b0, 16'h0000, "R1 wrap read back");
    repeat (5) @(negedge clk);
  endtask

  initial begin
    fork
      begin : run_blk
        main_seq();
      end
      begin : dog_blk
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule